// File: doc/BRIEF.md
# Exception Entry Arbiter

This block sits next to the retire stage of a simple in-order pipeline. Each clock it looks at the instruction that is retiring, at three level-sensitive asynchronous request lines (fast interrupt, normal interrupt, system error) and at its own mask state. From these it decides whether an exception is entered and which one. When an exception is entered it raises a one-cycle take pulse and a matching pipeline flush. It also reports a 3-bit class code, the handler vector address, the privilege level entered and the saved return address. All of these outputs are registered, so they appear one cycle after the inputs that caused them.

Leaving reset is itself an exception. On the first clock after reset is released, the block enters the highest privilege level at an address taken from a configuration input, and that entry outranks everything else. After that, the retiring instruction's own problem wins over any asynchronous request. That problem may be a fetch fault, a data access fault or one of three service calls. Asynchronous requests are serviced only when an instruction completes, and only if their class is not masked. Entering any exception sets all three mask bits. Software lowers the masks again through a simple write port.

The block has no streaming data path. Every pin is a plain control or status signal sampled each clock, so there is no valid/ready handshake and no back-pressure.

Top module: `exc_entry_arb`

## Requirements
- R1: On the first clock edge after `rst_n` is released, the block enters reset: on the following cycle `exc_take`=1, `exc_rst`=1, `exc_vector`=`rst_vec`, `exc_level`=TOP_LEVEL, `exc_class`=0 and `exc_ret_addr`=0. No other request is taken on that edge. While `rst_n` is low, `exc_take`=0 and `async_mask`=3'b111.
- R2: When `ret_valid` is sampled high outside a flush cycle, the retiring instruction's own exception is taken whatever the asynchronous requests and masks are. Among these, a fetch fault beats a data fault, and a data fault beats a service call.
- R3: `exc_class` is encoded as follows: 0 data fault, 1 fetch fault, 2 supervisor call, 3 hypervisor call, 4 secure-monitor call, 5 system error, 6 fast interrupt, 7 normal interrupt. `ret_call` is encoded as 0 none, 1 supervisor, 2 hypervisor, 3 secure monitor.
- R4: An asynchronous request is taken only in a cycle where `ret_valid` is sampled high outside a flush cycle, and only if its mask bit is 0. The mask bits are bit 0 system error, bit 1 fast interrupt and bit 2 normal interrupt. Among unmasked pending requests the order is system error, then fast, then normal.
- R5: A retiring instruction that is sampled while `flush` is high is discarded, together with any fault or call it carries.
- R6: For every entry other than reset, `exc_vector` is `vec_base` with bits 10:0 replaced by a class offset. The offset is 0x000 for the five synchronous classes, 0x080 for a normal interrupt, 0x100 for a fast interrupt and 0x180 for a system error.
- R7: `exc_ret_addr` is `ret_pc` for a fetch or data fault, and `ret_pc`+4 for a service call or an asynchronous entry. `exc_ret_addr`, `exc_class`, `exc_vector` and `exc_level` hold their values between entries. Non-reset entries use level HANDLER_LEVEL.
- R8: Every entry sets `async_mask` to 3'b111 in the same cycle that `exc_take` rises, and this overrides a mask write on the same edge. Without an entry, `mask_wr_en` loads `mask_wr_data` into `async_mask` on the next cycle.
- R9: `flush` equals `exc_take`, and the two are never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release triggers the reset entry |
| rst_vec | input | AW | Reset entry address, sampled on the release edge |
| vec_base | input | AW | Handler table base; bits 10:0 ignored |
| fiq_req | input | 1 | Fast interrupt request, level |
| irq_req | input | 1 | Normal interrupt request, level |
| serr_req | input | 1 | Asynchronous system-error request, level |
| mask_wr_en | input | 1 | Load the mask register |
| mask_wr_data | input | 3 | New mask value {normal, fast, system error} |
| ret_valid | input | 1 | An instruction completes this cycle |
| ret_pc | input | AW | Address of the completing instruction |
| ret_fetch_flt | input | 1 | Completing instruction had a fetch fault |
| ret_data_flt | input | 1 | Completing instruction's load/store faulted |
| ret_call | input | 2 | Service-call kind of the completing instruction |
| exc_take | output | 1 | One-cycle pulse: an exception is entered |
| exc_rst | output | 1 | The entry being reported is the reset entry |
| exc_class | output | 3 | Class code of the last entry |
| exc_level | output | LW | Privilege level entered by the last entry |
| exc_vector | output | AW | Handler address of the last entry |
| exc_ret_addr | output | AW | Saved return address of the last entry |
| flush | output | 1 | Pipeline flush request |
| async_mask | output | 3 | Current asynchronous mask bits |

## Verification
The arbiter is first driven with isolated sources. Each fault kind, each call kind and each interrupt line is applied alone, which checks every class code, vector offset and return-address rule separately. Overlapping patterns come next: a fault together with all three requests unmasked, a fetch fault together with a data fault and a call, and all requests together with selected mask bits set. These show whether the priority order is fixed, or whether masking moves the winner to the next source. Requests held while no instruction retires, and faults arriving in the flush cycle, show the difference between a pending condition and a taken one. A mask write on the same edge as an entry, followed by a second reset, checks the override rule and the reset re-entry.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    CLS_DATA  = 3'd0,
    CLS_FETCH = 3'd1,
    CLS_SUP   = 3'd2,
    CLS_HYP   = 3'd3,
    CLS_MON   = 3'd4,
    CLS_SERR  = 3'd5,
    CLS_FAST  = 3'd6,
    CLS_NORM  = 3'd7
  } exc_cls_e;

  localparam int MASK_W   = 3;
  localparam int MSK_SERR = 0;
  localparam int MSK_FAST = 1;
  localparam int MSK_NORM = 2;

  localparam int TBL_LSB  = 11;

  function automatic logic [TBL_LSB-1:0] tbl_offset(exc_cls_e c);
    case (c)
      CLS_NORM: tbl_offset = 11'h080;
      CLS_FAST: tbl_offset = 11'h100;
      CLS_SERR: tbl_offset = 11'h180;
      default:  tbl_offset = 11'h000;
    endcase
  endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
(
  input  logic              boundary,
  input  logic              fetch_flt,
  input  logic              data_flt,
  input  logic [1:0]        call_kind,
  input  logic [MASK_W-1:0] async_pend,
  output logic              hit,
  output exc_cls_e          cls,
  output logic              ret_next
);

  always_comb begin
    hit      = 1'b0;
    cls      = CLS_DATA;
    ret_next = 1'b0;
    if (boundary) begin
      hit = 1'b1;
      if (fetch_flt) begin
        cls = CLS_FETCH;
      end else if (data_flt) begin
        cls = CLS_DATA;
      end else if (call_kind != 2'd0) begin
        cls      = exc_cls_e'(3'(call_kind) + 3'd1);
        ret_next = 1'b1;
      end else if (async_pend[MSK_SERR]) begin
        cls      = CLS_SERR;
        ret_next = 1'b1;
      end else if (async_pend[MSK_FAST]) begin
        cls      = CLS_FAST;
        ret_next = 1'b1;
      end else if (async_pend[MSK_NORM]) begin
        cls      = CLS_NORM;
        ret_next = 1'b1;
      end else begin
        hit = 1'b0;
      end
    end
  end

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  exc_cls_e      cls,
  output logic [AW-1:0] vec
);

  assign vec = {base[AW-1:TBL_LSB], tbl_offset(cls)};

endmodule

// File: rtl/exc_mask_reg.sv
module exc_mask_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_all,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (set_all) mask_q <= '1;
    else if (wr_en)   mask_q <= wr_data;
  end

endmodule

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_pkg::*;
#(
  parameter int AW            = 32,
  parameter int LW            = 2,
  parameter int TOP_LEVEL     = 3,
  parameter int HANDLER_LEVEL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rst_vec,
  input  logic [AW-1:0]     vec_base,
  input  logic              fiq_req,
  input  logic              irq_req,
  input  logic              serr_req,
  input  logic              mask_wr_en,
  input  logic [MASK_W-1:0] mask_wr_data,
  input  logic              ret_valid,
  input  logic [AW-1:0]     ret_pc,
  input  logic              ret_fetch_flt,
  input  logic              ret_data_flt,
  input  logic [1:0]        ret_call,
  output logic              exc_take,
  output logic              exc_rst,
  output logic [2:0]        exc_class,
  output logic [LW-1:0]     exc_level,
  output logic [AW-1:0]     exc_vector,
  output logic [AW-1:0]     exc_ret_addr,
  output logic              flush,
  output logic [MASK_W-1:0] async_mask
);

  localparam logic [LW-1:0] TOP_L = LW'(TOP_LEVEL);
  localparam logic [LW-1:0] HND_L = LW'(HANDLER_LEVEL);
  localparam logic [AW-1:0] STEP  = AW'(4);

  logic              rst_pend_q;
  logic              take_q;
  logic              boundary;
  logic [MASK_W-1:0] pend;
  logic              hit;
  exc_cls_e          sel_cls;
  logic              ret_next;
  logic [AW-1:0]     vec_n;
  logic              enter;

  // an instruction completing in the flush cycle or during reset entry is dropped
  assign boundary = ret_valid && !take_q && !rst_pend_q;
  assign pend     = {irq_req, fiq_req, serr_req} & ~async_mask;
  assign enter    = rst_pend_q || hit;

  exc_prio_sel u_prio (
    .boundary   (boundary),
    .fetch_flt  (ret_fetch_flt),
    .data_flt   (ret_data_flt),
    .call_kind  (ret_call),
    .async_pend (pend),
    .hit        (hit),
    .cls        (sel_cls),
    .ret_next   (ret_next)
  );

  exc_vec_gen #(.AW(AW)) u_vec (
    .base (vec_base),
    .cls  (sel_cls),
    .vec  (vec_n)
  );

  exc_mask_reg #(.N(MASK_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_all (enter),
    .wr_en   (mask_wr_en),
    .wr_data (mask_wr_data),
    .mask_q  (async_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q   <= 1'b1;
      take_q       <= 1'b0;
      exc_rst      <= 1'b0;
      exc_class    <= '0;
      exc_level    <= '0;
      exc_vector   <= '0;
      exc_ret_addr <= '0;
    end else begin
      rst_pend_q <= 1'b0;
      take_q     <= enter;
      exc_rst    <= rst_pend_q;
      if (rst_pend_q) begin
        exc_class    <= '0;
        exc_level    <= TOP_L;
        exc_vector   <= rst_vec;
        exc_ret_addr <= '0;
      end else if (hit) begin
        exc_class    <= sel_cls;
        exc_level    <= HND_L;
        exc_vector   <= vec_n;
        exc_ret_addr <= ret_next ? ret_pc + STEP : ret_pc;
      end
    end
  end

  assign exc_take = take_q;
  assign flush    = take_q;

endmodule

// File: rtl/exc_entry_arb_chk.sv
module exc_entry_arb_chk #(
  parameter int AW        = 32,
  parameter int LW        = 2,
  parameter int TOP_LEVEL = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fiq_req,
  input logic          irq_req,
  input logic          serr_req,
  input logic          ret_valid,
  input logic          ret_fetch_flt,
  input logic          exc_take,
  input logic          exc_rst,
  input logic [2:0]    exc_class,
  input logic [LW-1:0] exc_level,
  input logic [AW-1:0] exc_vector,
  input logic [2:0]    async_mask
);

  // R1
  rst_entry_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_rst |-> (exc_take && exc_level == LW'(TOP_LEVEL)));

  // R9
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !exc_take);

  // R8
  mask_set_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> async_mask == 3'b111);

  // R6
  vec_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !exc_rst) |-> (exc_vector[6:0] == 7'd0 && exc_vector[10:9] == 2'd0));

  // R4
  fast_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !exc_rst && exc_class == 3'd6) |->
      $past(ret_valid && fiq_req && !async_mask[1]));

  // R4
  norm_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !exc_rst && exc_class == 3'd7) |->
      $past(ret_valid && irq_req && !async_mask[2]));

  // R4
  serr_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !exc_rst && exc_class == 3'd5) |->
      $past(ret_valid && serr_req && !async_mask[0]));

  // R2
  fetch_needs_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !exc_rst && exc_class == 3'd1) |-> $past(ret_valid && ret_fetch_flt));

endmodule

bind exc_entry_arb exc_entry_arb_chk #(.AW(AW), .LW(LW), .TOP_LEVEL(TOP_LEVEL)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fiq_req       (fiq_req),
  .irq_req       (irq_req),
  .serr_req      (serr_req),
  .ret_valid     (ret_valid),
  .ret_fetch_flt (ret_fetch_flt),
  .exc_take      (exc_take),
  .exc_rst       (exc_rst),
  .exc_class     (exc_class),
  .exc_level     (exc_level),
  .exc_vector    (exc_vector),
  .async_mask    (async_mask)
);

// File: tb/exc_entry_arb_bench.sv
module exc_entry_arb_bench;

  localparam int AW = 32;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rst_vec = 32'h0000_4000;
  logic [AW-1:0] vec_base = 32'h8000_0000;
  logic          fiq_req = 0, irq_req = 0, serr_req = 0;
  logic          mask_wr_en = 0;
  logic [2:0]    mask_wr_data = 0;
  logic          ret_valid = 0;
  logic [AW-1:0] ret_pc = 0;
  logic          ret_fetch_flt = 0, ret_data_flt = 0;
  logic [1:0]    ret_call = 0;
  logic          exc_take, exc_rst, flush;
  logic [2:0]    exc_class, async_mask;
  logic [LW-1:0] exc_level;
  logic [AW-1:0] exc_vector, exc_ret_addr;

  exc_entry_arb u_exc_entry_arb (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit          m_pend, m_take, m_rst;
  int          m_cls, m_lvl;
  logic [31:0] m_vec, m_ret;
  logic [2:0]  m_mask;

  task automatic cmp(string tag, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit ok, hit, nxt;
    int cls;
    logic [2:0] pend;
    if (!rst_n) begin
      m_pend = 1; m_take = 0; m_rst = 0; m_cls = 0; m_lvl = 0;
      m_vec = 0; m_ret = 0; m_mask = 3'b111;
    end else begin
      ok   = ret_valid && !m_take && !m_pend;
      pend = {irq_req, fiq_req, serr_req} & ~m_mask;
      hit = 0; nxt = 0; cls = 0;
      if (ok) begin
        hit = 1;
        if (ret_fetch_flt) cls = 1;
        else if (ret_data_flt) cls = 0;
        else if (ret_call != 0) begin cls = 1 + ret_call; nxt = 1; end
        else if (pend[0]) begin cls = 5; nxt = 1; end
        else if (pend[1]) begin cls = 6; nxt = 1; end
        else if (pend[2]) begin cls = 7; nxt = 1; end
        else hit = 0;
      end
      m_rst = m_pend;
      if (m_pend) begin
        m_cls = 0; m_lvl = 3; m_vec = rst_vec; m_ret = 0;
      end else if (hit) begin
        m_cls = cls; m_lvl = 1; m_ret = nxt ? ret_pc + 4 : ret_pc;
        m_vec = {vec_base[31:11], 11'h000};
        if (cls == 7) m_vec[10:0] = 11'h080;
        if (cls == 6) m_vec[10:0] = 11'h100;
        if (cls == 5) m_vec[10:0] = 11'h180;
      end
      m_take = m_pend || hit;
      if (m_take) m_mask = 3'b111;
      else if (mask_wr_en) m_mask = mask_wr_data;
      m_pend = 0;
    end
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "take",  exc_take,     m_take);
    cmp(tag, "flush", flush,        m_take);
    cmp(tag, "rst",   exc_rst,      m_rst);
    cmp(tag, "class", exc_class,    m_cls);
    cmp(tag, "level", exc_level,    m_lvl);
    cmp(tag, "vec",   exc_vector,   m_vec);
    cmp(tag, "ret",   exc_ret_addr, m_ret);
    cmp(tag, "mask",  async_mask,   m_mask);
    mask_wr_en = 0; ret_valid = 0; ret_fetch_flt = 0; ret_data_flt = 0; ret_call = 0;
  endtask

  task automatic wmask(logic [2:0] v, string tag);
    mask_wr_en = 1; mask_wr_data = v;
    step(tag);
  endtask

  task automatic retire(logic [31:0] pc, bit ff, bit df, logic [1:0] ck, string tag);
    ret_valid = 1; ret_pc = pc; ret_fetch_flt = ff; ret_data_flt = df; ret_call = ck;
    step(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) step("R1");
    rst_n = 1;
    step("R1");                                  // reset entry
    retire(32'h100, 1, 0, 0, "R5");              // flush cycle drops fetch fault
    wmask(3'b000, "R8");
    retire(32'h104, 0, 0, 0, "R2");              // plain retire, nothing taken
    irq_req = 1;
    step("R4");                                  // no boundary, no take
    retire(32'h108, 0, 0, 0, "R4");              // normal interrupt
    step("R9");
    wmask(3'b000, "R8");
    fiq_req = 1;
    retire(32'h200, 0, 0, 0, "R4");              // fast beats normal
    step("R9");
    wmask(3'b000, "R8");
    serr_req = 1; vec_base = 32'h1234_5fff;
    retire(32'h300, 0, 0, 0, "R6");              // system error first
    step("R9");
    wmask(3'b001, "R4");
    retire(32'h304, 0, 0, 0, "R4");              // error masked -> fast
    step("R9");
    wmask(3'b011, "R4");
    retire(32'h308, 0, 0, 0, "R4");              // -> normal
    step("R9");
    wmask(3'b111, "R4");
    retire(32'h30c, 0, 0, 0, "R4");              // all masked
    wmask(3'b000, "R8");
    retire(32'h400, 0, 1, 0, "R2");              // data fault beats all requests
    step("R9");
    wmask(3'b000, "R8");
    retire(32'h500, 1, 1, 2'd3, "R2");           // fetch beats data and call
    step("R9");
    serr_req = 0; fiq_req = 0; irq_req = 0;
    for (int k = 1; k < 4; k++) begin
      retire(32'h600 + 32'(k * 16), 0, 0, 2'(k), "R3"); // call classes 2..4
      step("R7");
    end
    retire(32'h700, 0, 1, 2'd1, "R2");           // data beats call
    step("R9");
    wmask(3'b000, "R8");
    irq_req = 1;
    mask_wr_en = 1; mask_wr_data = 3'b000;
    retire(32'h800, 0, 0, 0, "R8");              // write loses to entry
    step("R8");
    irq_req = 0;
    rst_vec = 32'h00ab_c000;
    rst_n = 0;
    step("R1");
    step("R1");
    rst_n = 1;
    step("R1");
    step("R9");
    finish_run();
  end

endmodule